// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache Controller

This block sits between a processor's memory stage and a variable-latency memory port. It serves loads from a direct-mapped array of one-word lines. Each line has a tag and a valid bit. The controller also hands stores to an external write buffer and applies that buffer's drained writes to any line that currently holds the same word. A load takes its data from the first of two places that has it. The write buffer comes first: it reports a match on its own inputs. The cache array comes second. On a hit in either place the data is returned combinationally, in the same cycle.

When a load misses both, the controller rejects the request before the end of that cycle and keeps rejecting it on every later cycle. The processor holds the same load while it is rejected. Meanwhile a three-state fill machine runs on the memory port: idle, request, wait. It issues a one-cycle read, waits any number of cycles for the ready pulse, then writes the returned word, its tag and its valid bit. The held load then hits on the following cycle. Stores never allocate a line. The cache only changes contents through fills and drains, which keeps memory and cache consistent without any dirty state.

Top module: `dcache_wt`

## Requirements
- R1: Reset clears every valid bit. The first load to any address after reset is rejected and starts a fill, including a load to an address that was cached before the reset.
- R2: A load with `wb_hit` high is never rejected and returns `wb_rdata` in the same cycle, whether the cache holds that word or not.
- R3: A load that hits a valid line with a matching tag is not rejected and returns the line's data in the same cycle, with no memory read.
- R4: A load that misses is rejected in the cycle it is presented. It is rejected again on every cycle until the line is filled. The miss causes exactly one `mem_read` pulse of one cycle, in the following cycle, with `mem_raddr` equal to the load address with bits [1:0] cleared.
- R5: The fill waits for `mem_ready` for any number of cycles. If `mem_ready` is high at edge k, counted from the read edge, the word is written at that edge. A load held from the start is then rejected for exactly k+2 cycles and returns `mem_rdata` on the next cycle.
- R6: A store with `wb_full` low raises `wb_push` in the same cycle, carrying `cpu_addr` and `cpu_wdata`, and is not rejected. A store with `wb_full` high is rejected and `wb_push` stays low.
- R7: A store never changes or allocates a cache line. A later load without a buffer match returns the old cached value, or misses if the word was not cached.
- R8: A drained write (`drain_valid`) updates the line only when that line is valid and its tag matches. A drain to a word that is not cached allocates nothing and leaves the resident line unchanged.
- R9: The line index is address bits [7:2] (64 lines) and the tag is bits [31:8]. Two addresses with the same index and different tags evict each other.
- R10: If a drain to the very word being filled arrives at the same edge as `mem_ready`, the line takes the drained data instead of `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ld | input | 1 | Load request, held while rejected |
| cpu_st | input | 1 | Store request, held while rejected |
| cpu_addr | input | 32 | Byte address of the word accessed |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a load is not rejected |
| cpu_reject | output | 1 | Request refused this cycle; retry next cycle |
| wb_hit | input | 1 | Write buffer holds the load address |
| wb_rdata | input | 32 | Write buffer data for the load address |
| wb_full | input | 1 | Write buffer has no free entry |
| wb_push | output | 1 | Enqueue a store into the write buffer |
| wb_push_addr | output | 32 | Address of the pushed store |
| wb_push_data | output | 32 | Data of the pushed store |
| drain_valid | input | 1 | Write buffer is draining a word to memory |
| drain_addr | input | 32 | Address of the drained word |
| drain_data | input | 32 | Data of the drained word |
| mem_read | output | 1 | One-cycle read request to the memory port |
| mem_raddr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Read completed this edge |

## Verification
The hardest case to reach from the ports is a drained write that lands on the same edge as the fill's ready pulse, for the same word. It needs the memory response and the write buffer drain aligned to one exact cycle. The bench's memory responder creates it: when a flag is set, it raises the drain inputs for the fill address together with `mem_ready`. A second hard case is proving that the reject lasts exactly as long as the memory latency. The responder takes a latency per vector, and the bench counts the rejected cycles against latency plus two.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
package dcache_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_WAIT = 2'd2
   } fill_state_t;
endpackage

// File: rtl/dcache_tags.sv
`timescale 1ns/1ps
module dcache_tags #(
   parameter int LINES = 64,
   parameter int TAG_W = 24,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   input  logic [IDX_W-1:0] dr_idx,
   input  logic [TAG_W-1:0] dr_tag,
   output logic             dr_hit,
   input  logic             fill_we,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag
);
   logic [LINES-1:0] valid_vec;
   logic [TAG_W-1:0] tag_arr [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      wire              sel = fill_we && (fill_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   v_q <= 1'b0;
         else if (sel) v_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) t_q <= fill_tag;
      end

      assign valid_vec[i] = v_q;
      assign tag_arr[i]   = t_q;
   end

   assign lk_hit = valid_vec[lk_idx] && (tag_arr[lk_idx] == lk_tag);
   assign dr_hit = valid_vec[dr_idx] && (tag_arr[dr_idx] == dr_tag);
endmodule

// File: rtl/dcache_data.sv
`timescale 1ns/1ps
module dcache_data #(
   parameter int LINES  = 64,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              fill_we,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              upd_we,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic [DATA_W-1:0] upd_data
);
   logic [DATA_W-1:0] words [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_word
      logic [DATA_W-1:0] w_q;
      always_ff @(posedge clk) begin
         if (fill_we && (fill_idx == IDX_W'(i)))     w_q <= fill_data;
         else if (upd_we && (upd_idx == IDX_W'(i)))  w_q <= upd_data;
      end
      assign words[i] = w_q;
   end

   assign rd_data = words[rd_idx];
endmodule

// File: rtl/dcache_fill.sv
`timescale 1ns/1ps
module dcache_fill
   import dcache_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              mem_ready,
   output logic              mem_read,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic              fill_done,
   output logic [ADDR_W-1:0] fill_addr
);
   fill_state_t       state_q, state_d;
   logic [ADDR_W-1:0] addr_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         FS_IDLE: if (start)     state_d = FS_REQ;
         FS_REQ:                 state_d = FS_WAIT;
         FS_WAIT: if (mem_ready) state_d = FS_IDLE;
         default:                state_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= FS_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           addr_q <= '0;
      else if (state_q == FS_IDLE && start) addr_q <= start_addr;
   end

   assign mem_read  = (state_q == FS_REQ);
   assign mem_raddr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign fill_done = (state_q == FS_WAIT) && mem_ready;
   assign fill_addr = addr_q;
endmodule

// File: rtl/dcache_wt.sv
`timescale 1ns/1ps
module dcache_wt #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LINES  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_ld,
   input  logic              cpu_st,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_reject,
   input  logic              wb_hit,
   input  logic [DATA_W-1:0] wb_rdata,
   input  logic              wb_full,
   output logic              wb_push,
   output logic [ADDR_W-1:0] wb_push_addr,
   output logic [DATA_W-1:0] wb_push_data,
   input  logic              drain_valid,
   input  logic [ADDR_W-1:0] drain_addr,
   input  logic [DATA_W-1:0] drain_data,
   output logic              mem_read,
   output logic [ADDR_W-1:0] mem_raddr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);
   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   if ((LINES & (LINES - 1)) != 0 || LINES < 2) begin : g_bad_lines
      $error("dcache_wt: LINES must be a power of two, at least 2");
   end
   if (DATA_W % 8 != 0 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("dcache_wt: DATA_W must be a power-of-two number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dcache_wt: address too narrow for the line count");
   end

   logic              lk_hit, dr_hit, fill_done, ld_miss;
   logic [ADDR_W-1:0] fill_addr;
   logic [DATA_W-1:0] line_data, fill_word;

   wire [IDX_W-1:0] cpu_idx  = cpu_addr[OFF_W +: IDX_W];
   wire [TAG_W-1:0] cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
   wire [IDX_W-1:0] dr_idx   = drain_addr[OFF_W +: IDX_W];
   wire [TAG_W-1:0] dr_tag   = drain_addr[ADDR_W-1 -: TAG_W];
   wire [IDX_W-1:0] fill_idx = fill_addr[OFF_W +: IDX_W];
   wire [TAG_W-1:0] fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

   dcache_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(cpu_idx), .lk_tag(cpu_tag), .lk_hit(lk_hit),
      .dr_idx(dr_idx), .dr_tag(dr_tag), .dr_hit(dr_hit),
      .fill_we(fill_done), .fill_idx(fill_idx), .fill_tag(fill_tag)
   );

   // A drain of the very word being filled is newer than the memory copy.
   assign fill_word = (drain_valid && drain_addr == fill_addr) ? drain_data : mem_rdata;

   dcache_data #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
      .clk(clk), .rd_idx(cpu_idx), .rd_data(line_data),
      .fill_we(fill_done), .fill_idx(fill_idx), .fill_data(fill_word),
      .upd_we(drain_valid && dr_hit), .upd_idx(dr_idx), .upd_data(drain_data)
   );

   dcache_fill #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fill (
      .clk(clk), .rst_n(rst_n),
      .start(ld_miss), .start_addr(cpu_addr),
      .mem_ready(mem_ready), .mem_read(mem_read), .mem_raddr(mem_raddr),
      .fill_done(fill_done), .fill_addr(fill_addr)
   );

   assign ld_miss      = cpu_ld && !wb_hit && !lk_hit;
   assign cpu_reject   = ld_miss || (cpu_st && wb_full);
   assign cpu_rdata    = wb_hit ? wb_rdata : line_data;
   assign wb_push      = cpu_st && !wb_full;
   assign wb_push_addr = cpu_addr;
   assign wb_push_data = cpu_wdata;
endmodule

// File: rtl/dcache_wt_chk.sv
`timescale 1ns/1ps
module dcache_wt_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ld,
   input logic              cpu_st,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              cpu_reject,
   input logic              wb_hit,
   input logic [DATA_W-1:0] wb_rdata,
   input logic              wb_full,
   input logic              wb_push,
   input logic              drain_valid,
   input logic              mem_read,
   input logic [ADDR_W-1:0] mem_raddr,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              mem_ready
);
   localparam int OFF_W = $clog2(DATA_W / 8);

   wire same_word = cpu_addr[ADDR_W-1:OFF_W] == mem_raddr[ADDR_W-1:OFF_W];

   assert_read_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_read |=> !mem_read);

   assert_read_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_read |-> (mem_raddr[OFF_W-1:0] == '0));

   assert_miss_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_read && cpu_ld && !cpu_st && !wb_hit && same_word) |-> cpu_reject);

   assert_wbuf_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ld && !cpu_st && wb_hit) |-> (!cpu_reject && cpu_rdata == wb_rdata));

   assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_st && wb_full) |-> (cpu_reject && !wb_push));

   assert_free_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_st && !cpu_ld && !wb_full) |-> (!cpu_reject && wb_push));

   assert_fill_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ready && cpu_ld && !cpu_st && !drain_valid && same_word) |=>
      (!(cpu_ld && !cpu_st && !wb_hit && $stable(cpu_addr)) ||
       (!cpu_reject && cpu_rdata == $past(mem_rdata))));
endmodule

bind dcache_wt dcache_wt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_ld(cpu_ld), .cpu_st(cpu_st),
   .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .cpu_reject(cpu_reject),
   .wb_hit(wb_hit), .wb_rdata(wb_rdata), .wb_full(wb_full), .wb_push(wb_push),
   .drain_valid(drain_valid), .mem_read(mem_read), .mem_raddr(mem_raddr),
   .mem_rdata(mem_rdata), .mem_ready(mem_ready)
);

// File: tb/dcache_wt_bench.sv
`timescale 1ns/1ps
module dcache_wt_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_ld, cpu_st, wb_hit, wb_full, drain_valid, mem_ready;
   logic [31:0] cpu_addr, cpu_wdata, wb_rdata, drain_addr, drain_data, mem_rdata;
   logic [31:0] cpu_rdata, wb_push_addr, wb_push_data, mem_raddr;
   logic        cpu_reject, wb_push, mem_read;

   always #2.5 clk = ~clk;

   dcache_wt u_dcache_wt (
      .clk(clk), .rst_n(rst_n), .cpu_ld(cpu_ld), .cpu_st(cpu_st),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_reject(cpu_reject), .wb_hit(wb_hit), .wb_rdata(wb_rdata),
      .wb_full(wb_full), .wb_push(wb_push), .wb_push_addr(wb_push_addr),
      .wb_push_data(wb_push_data), .drain_valid(drain_valid),
      .drain_addr(drain_addr), .drain_data(drain_data), .mem_read(mem_read),
      .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   int          n_chk = 0, n_bad = 0, n_reads = 0, resp_lat = 0;
   bit          done = 0, collide = 0;
   logic [31:0] last_raddr = '0, collide_data = '0;

   function automatic logic [31:0] memv(input logic [31:0] a);
      return a ^ 32'hC3C3_5A5A;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Memory port model: ready comes 1+lat edges after the read edge.
   initial begin
      mem_ready = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_read === 1'b1) begin
            logic [31:0] a;
            a = mem_raddr;
            last_raddr = a;
            n_reads++;
            @(negedge clk);
            repeat (resp_lat) @(negedge clk);
            mem_ready = 1'b1;
            mem_rdata = memv(a);
            if (collide) begin
               drain_valid = 1'b1;
               drain_addr  = a;
               drain_data  = collide_data;
            end
            @(negedge clk);
            mem_ready = 1'b0;
            if (collide) drain_valid = 1'b0;
         end
      end
   end

   task automatic do_load(input logic [31:0] addr, input bit wbh,
                          input logic [31:0] wbd, input logic [31:0] exp,
                          input bit miss, input int lat, input string req);
      int r0, rej;
      resp_lat = lat;
      r0 = n_reads;
      @(negedge clk);
      cpu_ld = 1'b1; cpu_addr = addr; wb_hit = wbh; wb_rdata = wbd;
      #1;
      rej = 0;
      while (cpu_reject && rej < 2000) begin
         rej++;
         @(negedge clk);
         #1;
      end
      chk(cpu_rdata == exp, {req, " load data"}, cpu_rdata, exp);
      chk(rej == (miss ? lat + 3 : 0), {req, " reject cycles (R4/R5)"}, rej,
          miss ? lat + 3 : 0);
      if (miss) begin
         chk(n_reads == r0 + 1, {req, " single read R4"}, n_reads - r0, 1);
         chk(last_raddr == {addr[31:2], 2'b00}, {req, " read address R4"},
             last_raddr, {addr[31:2], 2'b00});
      end else begin
         chk(n_reads == r0, {req, " no read on hit R3"}, n_reads - r0, 0);
      end
      @(negedge clk);
      cpu_ld = 1'b0; wb_hit = 1'b0;
   endtask

   task automatic do_store(input logic [31:0] addr, input logic [31:0] data,
                           input bit full, input string req);
      @(negedge clk);
      cpu_st = 1'b1; cpu_addr = addr; cpu_wdata = data; wb_full = full;
      #1;
      chk(cpu_reject == full, {req, " store reject"}, cpu_reject, full);
      chk(wb_push == !full, {req, " store push"}, wb_push, !full);
      if (!full) begin
         chk(wb_push_addr == addr, {req, " push addr"}, wb_push_addr, addr);
         chk(wb_push_data == data, {req, " push data"}, wb_push_data, data);
      end
      @(negedge clk);
      cpu_st = 1'b0; wb_full = 1'b0;
   endtask

   task automatic do_drain(input logic [31:0] addr, input logic [31:0] data);
      @(negedge clk);
      drain_valid = 1'b1; drain_addr = addr; drain_data = data;
      @(negedge clk);
      drain_valid = 1'b0;
   endtask

   // Vector: {kind[1:0], miss, wbh, lat[3:0], addr[31:0], data[31:0]}
   // kind 0: load expecting memory value, 3: load expecting data field,
   // kind 1: store with free buffer, kind 2: drain.
   localparam int NV = 16;
   localparam logic [71:0] VEC [NV] = '{
      {2'd0, 1'b1, 1'b0, 4'd0, 32'h0000_1004, 32'h0},          // R1 R4 R5 first miss
      {2'd0, 1'b0, 1'b0, 4'd0, 32'h0000_1004, 32'h0},          // R3 hit
      {2'd3, 1'b0, 1'b1, 4'd0, 32'h0000_1004, 32'hDEAD_0001},  // R2 buffer wins
      {2'd1, 1'b0, 1'b0, 4'd0, 32'h0000_1004, 32'h1111_1111},  // R6 store
      {2'd0, 1'b0, 1'b0, 4'd0, 32'h0000_1004, 32'h0},          // R7 line unchanged
      {2'd2, 1'b0, 1'b0, 4'd0, 32'h0000_1004, 32'h2222_2222},  // R8 drain cached
      {2'd3, 1'b0, 1'b0, 4'd0, 32'h0000_1004, 32'h2222_2222},  // R8 updated
      {2'd0, 1'b1, 1'b0, 4'd5, 32'h0000_2004, 32'h0},          // R9 conflict miss
      {2'd0, 1'b1, 1'b0, 4'd2, 32'h0000_1004, 32'h0},          // R9 evicted
      {2'd1, 1'b0, 1'b0, 4'd0, 32'h0000_10F8, 32'h3333_3333},  // R7 store uncached
      {2'd2, 1'b0, 1'b0, 4'd0, 32'h0000_10F8, 32'h3333_3333},  // R8 drain uncached
      {2'd0, 1'b1, 1'b0, 4'd1, 32'h0000_10F8, 32'h0},          // R7 R8 no allocate
      {2'd0, 1'b0, 1'b0, 4'd0, 32'h0000_10F8, 32'h0},          // R3 hit idx 62
      {2'd3, 1'b0, 1'b1, 4'd0, 32'h0000_2004, 32'hBEEF_0014},  // R2 uncached bypass
      {2'd2, 1'b0, 1'b0, 4'd0, 32'h0000_2004, 32'h4444_4444},  // R8 tag mismatch
      {2'd0, 1'b0, 1'b0, 4'd0, 32'h0000_1004, 32'h0}           // R8 line intact
   };

   initial begin
      rst_n = 1'b0;
      cpu_ld = 0; cpu_st = 0; wb_hit = 0; wb_full = 0; drain_valid = 0;
      cpu_addr = '0; cpu_wdata = '0; wb_rdata = '0; drain_addr = '0; drain_data = '0;
      repeat (3) @(negedge clk);
      #1;
      chk(cpu_reject == 1'b0, "R1 reset reject", cpu_reject, 0);
      chk(mem_read == 1'b0, "R1 reset mem_read", mem_read, 0);
      chk(wb_push == 1'b0, "R1 reset push", wb_push, 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [71:0] v;
         v = VEC[i];
         case (v[71:70])
            2'd0: do_load(v[63:32], v[68], v[31:0], memv(v[63:32]), v[69],
                          int'(v[67:64]), $sformatf("vec%0d R3/R4/R5/R7/R9", i));
            2'd3: do_load(v[63:32], v[68], v[31:0], v[31:0], v[69],
                          int'(v[67:64]), $sformatf("vec%0d R2/R8", i));
            2'd1: do_store(v[63:32], v[31:0], 1'b0, $sformatf("vec%0d R6", i));
            default: do_drain(v[63:32], v[31:0]);
         endcase
      end

      // R6: store against a full buffer is refused.
      do_store(32'h0000_3000, 32'h5555_5555, 1'b1, "R6 full");

      // R5: long memory latency.
      do_load(32'h0000_0040, 1'b0, '0, memv(32'h0000_0040), 1'b1, 12, "R5 long wait");

      // R10: drain of the filled word on the ready edge.
      collide = 1'b1;
      collide_data = 32'h7777_7777;
      do_load(32'h0000_0014, 1'b0, '0, 32'h7777_7777, 1'b1, 3, "R10 collide");
      collide = 1'b0;
      do_load(32'h0000_0014, 1'b0, '0, 32'h7777_7777, 1'b0, 0, "R10 kept");

      // R1: reset in mid-run forgets a cached line.
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      do_load(32'h0000_1004, 1'b0, '0, memv(32'h0000_1004), 1'b1, 0, "R1 after reset");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule